// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries from memory. A requester hands it a virtual address and the base address of a first-level table in a single valid/ready transfer. The walker reads one word from the first-level table. When that word asks for it, the walker reads one word from a second-level table. It then presents either a physical address or a fault on a result channel that also uses valid/ready.

A first-level entry has three possible outcomes. If its present bit is clear, the walk faults. If its large-page flag is set, the entry maps a whole 4 MiB region and the walk ends after one read. Otherwise the entry points to a 4 KB second-level table, and that table supplies the base of a 4 KB page. The walker handles one translation at a time. It accepts a new request only after the requester has taken the current result.

Memory reads use a request channel (valid/ready plus a word address) and a response strobe that carries the returned data. The memory may stall the request and may answer after any delay.

Top module: `xw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `res_valid` and `mem_rd_valid` are 0.
- R2: The cycle after a request is accepted, `mem_rd_valid` is 1 with `mem_rd_addr` = {dirbase[31:12], vaddr[31:22], 2'b00}. Any set bits in dirbase[11:0] are discarded.
- R3: While `mem_rd_valid` is 1 and `mem_rd_ready` is 0, the walker keeps `mem_rd_valid` high and `mem_rd_addr` unchanged. It raises no new read between the accepted read and its response.
- R4: If bit 0 (present) of the first-level entry is 0, the cycle after its response shows `res_valid`=1, `res_fault`=1, `res_paddr`=0 and `res_large`=0. No second read follows.
- R5: If the first-level entry has bit 0 = 1 and bit 7 (large page) = 1, the cycle after its response shows `res_valid`=1, `res_fault`=0, `res_large`=1 and `res_paddr` = {entry[31:22], vaddr[21:0]}. No second read follows.
- R6: If the first-level entry has bit 0 = 1 and bit 7 = 0, the cycle after its response shows `mem_rd_valid`=1 with `mem_rd_addr` = {entry[31:12], vaddr[21:12], 2'b00}. The entry's other low bits have no effect.
- R7: If bit 0 of the second-level entry is 0, the cycle after its response shows `res_valid`=1, `res_fault`=1, `res_paddr`=0 and `res_large`=0.
- R8: If bit 0 of the second-level entry is 1, the cycle after its response shows `res_valid`=1, `res_fault`=0, `res_large`=0 and `res_paddr` = {entry[31:12], vaddr[11:0]}.
- R9: From the acceptance of a request until its result is accepted, `req_ready` is 0. While `res_valid` is 1 and `res_ready` is 0, the result fields hold. The cycle after the result is taken, `res_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker is idle and takes a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_dirbase | input | 32 | Base address of the first-level table |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 32 | Returned entry word |
| res_valid | output | 1 | Translation result present |
| res_ready | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Physical address (0 on a fault) |
| res_fault | output | 1 | Walk ended on a non-present entry |
| res_large | output | 1 | Result maps a 4 MiB page |

## Verification
Each result is due exactly one cycle after the event that causes it:
- The first-level read appears one cycle after request acceptance.
- The second-level read, or the result, appears one cycle after the first-level response.
- The result appears one cycle after the second-level response.

The bench drives every input at the falling edge and checks the outputs at the next falling edge after the edge it expects to matter. So each check looks at a single, known cycle rather than polling. During memory stalls, response delays and result back-pressure, the bench checks every intermediate cycle for held values and for the absence of extra reads.

// File: rtl/xw_pkg.sv
package xw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2,
    ST_DONE = 2'd3
  } walk_st_e;

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int W          = 32,
  parameter int DIR_IDX_W  = 10,
  parameter int TBL_IDX_W  = 10,
  parameter int PAGE_OFF_W = 12,
  parameter int ENT_BYTES  = 4
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] vaddr,
  input  logic [W-1:0] dir_entry,
  output logic [W-1:0] dir_addr,
  output logic [W-1:0] tbl_addr
);

  localparam int ENT_SH    = $clog2(ENT_BYTES);
  localparam int LARGE_SH  = TBL_IDX_W + PAGE_OFF_W;
  localparam logic [W-1:0] PAGE_MASK = {W{1'b1}} << PAGE_OFF_W;

  function automatic logic [W-1:0] dir_slot(input logic [W-1:0] b, input logic [W-1:0] va);
    logic [W-1:0] idx;
    idx = (va >> LARGE_SH) & W'((1 << DIR_IDX_W) - 1);
    return (b & PAGE_MASK) + (idx << ENT_SH);
  endfunction

  function automatic logic [W-1:0] tbl_slot(input logic [W-1:0] e, input logic [W-1:0] va);
    logic [W-1:0] idx;
    idx = (va >> PAGE_OFF_W) & W'((1 << TBL_IDX_W) - 1);
    return (e & PAGE_MASK) + (idx << ENT_SH);
  endfunction

  assign dir_addr = dir_slot(base, vaddr);
  assign tbl_addr = tbl_slot(dir_entry, vaddr);

endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec #(
  parameter int W           = 32,
  parameter int PAGE_OFF_W  = 12,
  parameter int LARGE_OFF_W = 22,
  parameter int PRESENT_BIT = 0,
  parameter int HUGE_BIT    = 7
) (
  input  logic [W-1:0] entry,
  input  logic [W-1:0] vaddr,
  output logic         present,
  output logic         huge,
  output logic [W-1:0] large_pa,
  output logic [W-1:0] small_pa
);

  function automatic logic [W-1:0] splice(input logic [W-1:0] e, input logic [W-1:0] va,
                                          input int off_w);
    logic [W-1:0] hi_mask;
    hi_mask = {W{1'b1}} << off_w;
    return (e & hi_mask) | (va & ~hi_mask);
  endfunction

  assign present  = entry[PRESENT_BIT];
  assign huge     = entry[HUGE_BIT];
  assign large_pa = splice(entry, vaddr, LARGE_OFF_W);
  assign small_pa = splice(entry, vaddr, PAGE_OFF_W);

endmodule

// File: rtl/xw_fsm.sv
module xw_fsm
  import xw_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     rd_ready,
  input  logic     rsp_valid,
  input  logic     res_ready,
  input  logic     dir_present,
  input  logic     dir_huge,
  output walk_st_e st,
  output logic     req_ready,
  output logic     rd_valid,
  output logic     res_valid,
  output logic     ev_accept,
  output logic     ev_dir_rsp,
  output logic     ev_tbl_rsp
);

  logic issued;

  always_comb begin
    req_ready  = (st == ST_IDLE);
    res_valid  = (st == ST_DONE);
    rd_valid   = ((st == ST_DIR) || (st == ST_TBL)) && !issued;
    ev_accept  = req_ready && req_valid;
    ev_dir_rsp = (st == ST_DIR) && issued && rsp_valid;
    ev_tbl_rsp = (st == ST_TBL) && issued && rsp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      issued <= 1'b0;
    end else begin
      if (rd_valid && rd_ready) issued <= 1'b1;
      case (st)
        ST_IDLE: if (ev_accept) begin
          st     <= ST_DIR;
          issued <= 1'b0;
        end
        ST_DIR: if (ev_dir_rsp) begin
          issued <= 1'b0;
          st     <= (!dir_present || dir_huge) ? ST_DONE : ST_TBL;
        end
        ST_TBL: if (ev_tbl_rsp) begin
          issued <= 1'b0;
          st     <= ST_DONE;
        end
        default: if (res_ready) st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xw_walker.sv
module xw_walker
  import xw_pkg::*;
#(
  parameter int W           = 32,
  parameter int DIR_IDX_W   = 10,
  parameter int TBL_IDX_W   = 10,
  parameter int PAGE_OFF_W  = 12,
  parameter int ENT_BYTES   = 4,
  parameter int PRESENT_BIT = 0,
  parameter int HUGE_BIT    = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_vaddr,
  input  logic [W-1:0] req_dirbase,
  output logic         mem_rd_valid,
  input  logic         mem_rd_ready,
  output logic [W-1:0] mem_rd_addr,
  input  logic         mem_rsp_valid,
  input  logic [W-1:0] mem_rsp_data,
  output logic         res_valid,
  input  logic         res_ready,
  output logic [W-1:0] res_paddr,
  output logic         res_fault,
  output logic         res_large
);

  localparam int LARGE_OFF_W = TBL_IDX_W + PAGE_OFF_W;

  walk_st_e     st;
  logic         ev_accept, ev_dir_rsp, ev_tbl_rsp;
  logic [W-1:0] va_q, base_q, dir_q;
  logic [W-1:0] dir_addr, tbl_addr, large_pa, small_pa;
  logic         ent_present, ent_huge;

  xw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rd_ready   (mem_rd_ready),
    .rsp_valid  (mem_rsp_valid),
    .res_ready  (res_ready),
    .dir_present(ent_present),
    .dir_huge   (ent_huge),
    .st         (st),
    .req_ready  (req_ready),
    .rd_valid   (mem_rd_valid),
    .res_valid  (res_valid),
    .ev_accept  (ev_accept),
    .ev_dir_rsp (ev_dir_rsp),
    .ev_tbl_rsp (ev_tbl_rsp)
  );

  xw_addr_gen #(
    .W(W), .DIR_IDX_W(DIR_IDX_W), .TBL_IDX_W(TBL_IDX_W),
    .PAGE_OFF_W(PAGE_OFF_W), .ENT_BYTES(ENT_BYTES)
  ) u_addr (
    .base     (base_q),
    .vaddr    (va_q),
    .dir_entry(dir_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr)
  );

  xw_entry_dec #(
    .W(W), .PAGE_OFF_W(PAGE_OFF_W), .LARGE_OFF_W(LARGE_OFF_W),
    .PRESENT_BIT(PRESENT_BIT), .HUGE_BIT(HUGE_BIT)
  ) u_dec (
    .entry   (mem_rsp_data),
    .vaddr   (va_q),
    .present (ent_present),
    .huge    (ent_huge),
    .large_pa(large_pa),
    .small_pa(small_pa)
  );

  assign mem_rd_addr = (st == ST_TBL) ? tbl_addr : dir_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q      <= '0;
      base_q    <= '0;
      dir_q     <= '0;
      res_paddr <= '0;
      res_fault <= 1'b0;
      res_large <= 1'b0;
    end else begin
      if (ev_accept) begin
        va_q   <= req_vaddr;
        base_q <= req_dirbase;
      end
      if (ev_dir_rsp) begin
        dir_q     <= mem_rsp_data;
        res_fault <= !ent_present;
        res_large <= ent_present && ent_huge;
        res_paddr <= (ent_present && ent_huge) ? large_pa : '0;
      end
      if (ev_tbl_rsp) begin
        res_fault <= !ent_present;
        res_large <= 1'b0;
        res_paddr <= ent_present ? small_pa : '0;
      end
    end
  end

endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic [W-1:0] req_vaddr,
  input logic [W-1:0] req_dirbase,
  input logic         mem_rd_valid,
  input logic         mem_rd_ready,
  input logic [W-1:0] mem_rd_addr,
  input logic [W-1:0] mem_rsp_data,
  input logic         res_valid,
  input logic         res_ready,
  input logic [W-1:0] res_paddr,
  input logic         res_fault,
  input logic         res_large,
  input logic         ev_dir_rsp
);

  // R2
  p_dir_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_rd_valid &&
      mem_rd_addr == {$past(req_dirbase[31:12]), $past(req_vaddr[31:22]), 2'b00}));

  // R3
  p_hold_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R4
  p_dir_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dir_rsp && !mem_rsp_data[0]) |=> (res_valid && res_fault && res_paddr == '0 && !mem_rd_valid));

  // R5
  p_large_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dir_rsp && mem_rsp_data[0] && mem_rsp_data[7]) |=> (res_valid && res_large && !res_fault && !mem_rd_valid));

  // R6
  p_tbl_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dir_rsp && mem_rsp_data[0] && !mem_rsp_data[7]) |=> (mem_rd_valid && !res_valid &&
      mem_rd_addr[31:12] == $past(mem_rsp_data[31:12])));

  // R7
  p_fault_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> (res_paddr == '0 && !res_large));

  // R9
  p_hold_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_paddr) && $stable(res_fault) && $stable(res_large)));

  // R9
  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || mem_rd_valid) |-> !req_ready);

endmodule

bind xw_walker xw_walker_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .req_dirbase (req_dirbase),
  .mem_rd_valid(mem_rd_valid),
  .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr (mem_rd_addr),
  .mem_rsp_data(mem_rsp_data),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_paddr   (res_paddr),
  .res_fault   (res_fault),
  .res_large   (res_large),
  .ev_dir_rsp  (ev_dir_rsp)
);

// File: tb/xw_walker_test.sv
module xw_walker_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_dirbase = '0;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic        res_large;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] ov_addr [4];
  logic [31:0] ov_data [4];

  always #2 clk = ~clk;

  xw_walker uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] x;
    for (int i = 0; i < 4; i++) if (ov_addr[i] == a) return ov_data[i];
    x = a * 32'h9E37_79B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EB_CA77;
    x = x ^ (x >> 13);
    return x;
  endfunction

  function automatic logic [31:0] exp_dir(input logic [31:0] b, input logic [31:0] va);
    return {b[31:12], va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] exp_tbl(input logic [31:0] e, input logic [31:0] va);
    return {e[31:12], va[21:12], 2'b00};
  endfunction

  // Serve one read: bench is at the negedge where the request must be visible.
  task automatic serve(input logic [31:0] exp_addr, input string req, output logic [31:0] data);
    int stall = $urandom % 3;
    int lat   = $urandom % 3;
    chk(mem_rd_valid === 1'b1, req, "read request due", {31'b0, mem_rd_valid}, 32'h1);
    chk(mem_rd_addr === exp_addr, req, "read address", mem_rd_addr, exp_addr);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_rd_valid === 1'b1 && mem_rd_addr === exp_addr, "R3", "held read under stall",
          mem_rd_addr, exp_addr);
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    for (int i = 0; i < lat; i++) begin
      chk(mem_rd_valid === 1'b0 && res_valid === 1'b0, "R3", "no extra read while waiting",
          {30'b0, mem_rd_valid, res_valid}, 32'h0);
      chk(req_ready === 1'b0, "R9", "busy while waiting", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
    end
    data = mem_word(exp_addr);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = $urandom;
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base);
    logic [31:0] pde, pte, exp_pa;
    logic        exp_fault, exp_large;
    string       rq;
    int          hold;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9", "idle ready", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1;
    req_vaddr = va;
    req_dirbase = base;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = $urandom;
    req_dirbase = $urandom;
    serve(exp_dir(base, va), "R2", pde);
    if (!pde[0]) begin
      rq = "R4"; exp_fault = 1; exp_large = 0; exp_pa = '0;
    end else if (pde[7]) begin
      rq = "R5"; exp_fault = 0; exp_large = 1; exp_pa = {pde[31:22], va[21:0]};
    end else begin
      serve(exp_tbl(pde, va), "R6", pte);
      exp_large = 0;
      if (!pte[0]) begin
        rq = "R7"; exp_fault = 1; exp_pa = '0;
      end else begin
        rq = "R8"; exp_fault = 0; exp_pa = {pte[31:12], va[11:0]};
      end
    end
    chk(res_valid === 1'b1 && mem_rd_valid === 1'b0, rq, "result due, no further read",
        {30'b0, res_valid, mem_rd_valid}, 32'h2);
    chk(res_paddr === exp_pa, rq, "physical address", res_paddr, exp_pa);
    chk(res_fault === exp_fault && res_large === exp_large, rq, "fault/large flags",
        {30'b0, res_fault, res_large}, {30'b0, exp_fault, exp_large});
    hold = $urandom % 3;
    req_valid = 1'b1;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(res_valid === 1'b1 && res_paddr === exp_pa && res_fault === exp_fault,
          "R9", "result held", res_paddr, exp_pa);
      chk(req_ready === 1'b0, "R9", "no new request while result pending",
          {31'b0, req_ready}, 32'h0);
    end
    req_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(res_valid === 1'b0 && req_ready === 1'b1, "R9", "release after result taken",
        {30'b0, res_valid, req_ready}, 32'h1);
  endtask

  task automatic clear_ov();
    for (int i = 0; i < 4; i++) begin
      ov_addr[i] = 32'h0000_0003;
      ov_data[i] = '0;
    end
  endtask

  initial begin
    logic [31:0] va, base;
    void'($urandom(32'd20240611));
    clear_ov();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready === 1'b1 && res_valid === 1'b0 && mem_rd_valid === 1'b0, "R1", "reset outputs",
        {29'b0, req_ready, res_valid, mem_rd_valid}, 32'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && res_valid === 1'b0 && mem_rd_valid === 1'b0, "R1", "after reset release",
        {29'b0, req_ready, res_valid, mem_rd_valid}, 32'h4);

    // R4 directed: non-present first-level entry with noisy upper bits
    va = 32'h1234_5678; base = 32'h0004_0000;
    ov_addr[0] = exp_dir(base, va); ov_data[0] = 32'hFFFF_F0FE;
    walk(va, base);

    // R5 directed: large page
    va = 32'hABCD_EF12; base = 32'h0008_0000;
    ov_addr[0] = exp_dir(base, va); ov_data[0] = 32'h8040_0081;
    walk(va, base);

    // R6/R8 directed: small page, dirbase low bits set (R2), noisy low entry bits
    va = 32'hFFFF_FFFF; base = 32'h0001_2FFF;
    ov_addr[0] = exp_dir(base, va); ov_data[0] = 32'h1234_5F7D;
    ov_addr[1] = exp_tbl(32'h1234_5F7D, va); ov_data[1] = 32'hCAFE_B003;
    walk(va, base);

    // R7 directed: non-present second-level entry
    va = 32'h0000_0000; base = 32'h0020_0000;
    ov_addr[0] = exp_dir(base, va); ov_data[0] = 32'h0030_0001;
    ov_addr[1] = exp_tbl(32'h0030_0001, va); ov_data[1] = 32'hCAFE_BFFE;
    walk(va, base);

    clear_ov();
    for (int n = 0; n < 80; n++) begin
      va = $urandom;
      base = $urandom;
      walk(va, base);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule